// File: doc/BRIEF.md
# PCI 64-bit Initiator Data Steering

This block is the data path of a PCI initiator that can use the 64-bit bus extension. A transaction starts with a one-cycle `start_i` pulse that carries a command class and a length in DWORDs. Write data is not buffered inside the block. The block presents a DWORD index on `wq_idx_o`, and the attached write queue must return, in the same cycle, the DWORD at that index on `wq_lo_i` and the next DWORD on `wq_hi_i`, each with its active-low byte enables.

For memory writes and prefetchable memory reads, the block raises the 64-bit request together with the frame. It then samples the target's 64-bit acknowledge in the first cycle where device select is seen, and that single sample sets the width of every data phase that follows:

- **Wide target:** each phase moves two DWORDs.
- **32-bit target:** each phase moves one DWORD. The upper DWORD that was pending on the high lanes, together with its byte enables, is steered onto the low lanes in the next phase.

Received read data is handed on through a registered return port. For 64-bit phases, the upper half is parity-checked against the target's upper parity bit.

All bus signals are modelled as active-high levels (1 means asserted). Byte enables keep the bus convention: 0 enables a byte lane and all ones disables it. Arbitration, address and command phases, the latency timer and retries belong to the surrounding initiator.

Top module: `pci64_init_steer`

## Requirements
- R1: While `rst_n` is low, and before any start, the outputs are as follows: `frame_o`, `req64_o`, `irdy_o`, `rd_valid_o` and `perr_o` are 0, `ad_o` is 0, `cbe_o` is 8'hFF and `wq_idx_o` is 0.
- R2: Commands are encoded on `cmd_i` as 0 = memory write, 1 = prefetchable memory read, 2 = other memory read and 3 = I/O or configuration. `req64_o` is high exactly while `frame_o` is high for commands 0 and 1, and it is never high for commands 2 and 3.
- R3: The width decision is taken from `ack64_i` in the first cycle where `devsel_i` is high during data phases, and only if the request was 64-bit. Later values of `ack64_i` are ignored. On a wide decision, each completed phase advances `wq_idx_o` by 2. During writes, the phase drives DWORD idx on `ad_o[31:0]` and DWORD idx+1 on `ad_o[63:32]`, with the enables to match on `cbe_o[3:0]` and `cbe_o[7:4]`.
- R4: On a narrow decision, each completed phase advances `wq_idx_o` by 1. A write therefore drives the DWORD that was pending on the upper lanes, together with its enables, on `ad_o[31:0]` and `cbe_o[3:0]` in the following phase.
- R5: In a write phase where the upper lanes are in use and idx+1 is not below the length (an odd final DWORD), `cbe_o[7:4]` is 4'hF. `ad_o[63:32]` still carries the queue's defined value.
- R6: During read data phases, `cbe_o[3:0]` is 0. `cbe_o[7:4]` is 0 while the upper lanes are in use (a 64-bit request that has not been refused), and 4'hF otherwise.
- R7: A phase completes only in a cycle where `irdy_o`, `devsel_i` and `trdy_i` are all high. Otherwise the index, `ad_o` and `cbe_o` hold.
- R8: One cycle after each completed read phase, `rd_valid_o` is high for one cycle. `rd_wide_o` gives the phase width. `rd_data_o` holds the full `ad_i` for a wide phase, or `ad_i[31:0]` zero-extended for a narrow phase.
- R9: One cycle after a completed wide read phase, `perr_o` is high exactly when `ad_i[63:32]`, `cbe_o[7:4]` and `par64_i` of that phase hold an odd number of ones. It is 0 in every other cycle.
- R10: A `start_i` pulse is ignored while a transaction is in progress (`frame_o` high), and no second transaction follows from it.
- R11: The frame and data timing works as follows. `frame_o` rises in the cycle after an accepted start. `irdy_o` rises one cycle later. Both fall in the cycle after the phase that reaches the length. Once a narrow decision is taken, `cbe_o[7:4]` is 4'hF and `ad_o[63:32]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a transaction |
| cmd_i | input | 2 | Command class (see R2) |
| len_i | input | LEN_W | Transaction length in DWORDs, at least 1 |
| wq_idx_o | output | LEN_W+1 | DWORD index requested from the write queue |
| wq_lo_i | input | DW_W | Queue DWORD at the index |
| wq_hi_i | input | DW_W | Queue DWORD at index + 1 |
| wq_be_lo_i | input | DW_W/8 | Active-low enables of the DWORD at the index |
| wq_be_hi_i | input | DW_W/8 | Active-low enables of the DWORD at index + 1 |
| frame_o | output | 1 | Transaction in progress |
| req64_o | output | 1 | 64-bit transfer request |
| irdy_o | output | 1 | Initiator ready, high in data phases |
| devsel_i | input | 1 | Target claims the transaction |
| trdy_i | input | 1 | Target ready |
| ack64_i | input | 1 | Target accepts 64-bit transfers |
| ad_o | output | 2*DW_W | Write data lanes |
| cbe_o | output | 2*DW_W/8 | Active-low byte enables |
| ad_i | input | 2*DW_W | Read data lanes from the target |
| par64_i | input | 1 | Target parity over the upper lanes |
| rd_valid_o | output | 1 | Read data returned |
| rd_wide_o | output | 1 | Returned data is 64 bits wide |
| rd_data_o | output | 2*DW_W | Returned read data |
| perr_o | output | 1 | Upper-lane parity mismatch |

## Verification
The bench builds the block with its default parameters: 32-bit DWORDs and a 6-bit length. Lengths from 1 to 20 DWORDs are used, so odd and even endings, single-DWORD transfers and long runs of wait states are all exercised. The target model varies the device-select delay, the first acknowledge sample and the ready pattern. It also toggles the acknowledge after the decision and corrupts upper parity on chosen phases. This brings within reach all four command classes and both widths, as well as the ignored restart.

// File: rtl/pci64_steer_pkg.sv
package pci64_steer_pkg;

  typedef enum logic [1:0] {
    CMD_MEM_WR    = 2'd0,
    CMD_MEM_RD_PF = 2'd1,
    CMD_MEM_RD    = 2'd2,
    CMD_IO_CFG    = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } st_e;

  // Only memory writes and prefetchable reads may ask for the wide path.
  function automatic logic cmd_uses64(input cmd_e c);
    return (c == CMD_MEM_WR) || (c == CMD_MEM_RD_PF);
  endfunction

  function automatic logic cmd_is_write(input cmd_e c);
    return c == CMD_MEM_WR;
  endfunction

endpackage

// File: rtl/pci64_phase_ctrl.sv
module pci64_phase_ctrl
  import pci64_steer_pkg::*;
#(
  parameter int LEN_W = 6,
  localparam int PTR_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  cmd_e             cmd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             devsel_i,
  input  logic             trdy_i,
  input  logic             ack64_i,
  output logic             frame_o,
  output logic             irdy_o,
  output logic             req64_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [LEN_W-1:0] len_o,
  output cmd_e             cmd_o,
  output logic             is_wr_o,
  output logic             hi_on_o,
  output logic             xfer_o,
  output logic             wide_now_o,
  output logic             seen_o,
  output logic             wide_dec_o
);

  st_e              st_q;
  cmd_e             cmd_q;
  logic [LEN_W-1:0] len_q;
  logic [PTR_W-1:0] ptr_q;
  logic             seen_q, wide_q, req64_q;

  logic             in_data, first_dev, wide_now, xfer, done;
  logic [PTR_W-1:0] ptr_nxt;

  // Pointer step per completed phase: two DWORDs wide, one narrow.
  function automatic logic [PTR_W-1:0] step_of(input logic wide);
    return wide ? PTR_W'(2) : PTR_W'(1);
  endfunction

  assign in_data   = (st_q == ST_DATA);
  assign first_dev = in_data && devsel_i && !seen_q;
  assign wide_now  = seen_q ? wide_q : (req64_q && ack64_i);
  assign xfer      = in_data && devsel_i && trdy_i;
  assign ptr_nxt   = ptr_q + step_of(wide_now);
  assign done      = xfer && (ptr_nxt >= {1'b0, len_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cmd_q   <= CMD_MEM_WR;
      len_q   <= '0;
      ptr_q   <= '0;
      seen_q  <= 1'b0;
      wide_q  <= 1'b0;
      req64_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_ADDR;
          cmd_q   <= cmd_i;
          len_q   <= len_i;
          ptr_q   <= '0;
          seen_q  <= 1'b0;
          wide_q  <= 1'b0;
          req64_q <= cmd_uses64(cmd_i);
        end
        ST_ADDR: st_q <= ST_DATA;
        ST_DATA: begin
          if (first_dev) begin
            seen_q <= 1'b1;
            wide_q <= req64_q && ack64_i;
          end
          if (xfer) ptr_q <= ptr_nxt;
          if (done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign frame_o    = (st_q != ST_IDLE);
  assign irdy_o     = in_data;
  assign req64_o    = frame_o && req64_q;
  assign ptr_o      = ptr_q;
  assign len_o      = len_q;
  assign cmd_o      = cmd_q;
  assign is_wr_o    = cmd_is_write(cmd_q);
  assign hi_on_o    = in_data && req64_q && (!seen_q || wide_q);
  assign xfer_o     = xfer;
  assign wide_now_o = wide_now;
  assign seen_o     = seen_q;
  assign wide_dec_o = wide_q;

endmodule

// File: rtl/pci64_lane_steer.sv
module pci64_lane_steer #(
  parameter int DW_W  = 32,
  parameter int LEN_W = 6,
  localparam int PTR_W = LEN_W + 1,
  localparam int BE_W  = DW_W / 8
) (
  input  logic              active_i,
  input  logic              is_wr_i,
  input  logic              hi_on_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DW_W-1:0]   wq_lo_i,
  input  logic [DW_W-1:0]   wq_hi_i,
  input  logic [BE_W-1:0]   wq_be_lo_i,
  input  logic [BE_W-1:0]   wq_be_hi_i,
  output logic [2*DW_W-1:0] ad_o,
  output logic [2*BE_W-1:0] cbe_o
);

  logic hi_valid;

  // The upper DWORD exists only while idx+1 is still below the length.
  function automatic logic upper_in_range(input logic [PTR_W-1:0] p,
                                          input logic [LEN_W-1:0] n);
    return (p + PTR_W'(1)) < {1'b0, n};
  endfunction

  assign hi_valid = upper_in_range(ptr_i, len_i);

  always_comb begin
    ad_o  = '0;
    cbe_o = '1;
    if (active_i) begin
      if (is_wr_i) begin
        ad_o[DW_W-1:0]  = wq_lo_i;
        cbe_o[BE_W-1:0] = wq_be_lo_i;
        if (hi_on_i) begin
          ad_o[2*DW_W-1:DW_W]  = wq_hi_i;
          cbe_o[2*BE_W-1:BE_W] = hi_valid ? wq_be_hi_i : '1;
        end
      end else begin
        cbe_o[BE_W-1:0] = '0;
        if (hi_on_i) cbe_o[2*BE_W-1:BE_W] = '0;
      end
    end
  end

endmodule

// File: rtl/pci64_rd_capture.sv
module pci64_rd_capture #(
  parameter int DW_W = 32,
  localparam int BE_W = DW_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_i,
  input  logic              is_rd_i,
  input  logic              wide_i,
  input  logic [2*DW_W-1:0] ad_i,
  input  logic              par64_i,
  input  logic [BE_W-1:0]   cbe_hi_i,
  output logic              rd_valid_o,
  output logic              rd_wide_o,
  output logic [2*DW_W-1:0] rd_data_o,
  output logic              perr_o
);

  logic            chk_q, par_q;
  logic [DW_W-1:0] hi_q;
  logic [BE_W-1:0] be_q;

  // Even parity: data, enables and parity bit together hold an even count.
  function automatic logic parity_bad(input logic [DW_W-1:0] d,
                                      input logic [BE_W-1:0] b,
                                      input logic p);
    return ^{d, b, p};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_wide_o  <= 1'b0;
      rd_data_o  <= '0;
      chk_q      <= 1'b0;
      par_q      <= 1'b0;
      hi_q       <= '0;
      be_q       <= '0;
    end else begin
      rd_valid_o <= xfer_i && is_rd_i;
      chk_q      <= xfer_i && is_rd_i && wide_i;
      if (xfer_i && is_rd_i) begin
        rd_wide_o <= wide_i;
        rd_data_o <= wide_i ? ad_i : {{DW_W{1'b0}}, ad_i[DW_W-1:0]};
        hi_q      <= ad_i[2*DW_W-1:DW_W];
        be_q      <= cbe_hi_i;
        par_q     <= par64_i;
      end
    end
  end

  assign perr_o = chk_q && parity_bad(hi_q, be_q, par_q);

endmodule

// File: rtl/pci64_init_steer.sv
module pci64_init_steer
  import pci64_steer_pkg::*;
#(
  parameter int DW_W  = 32,
  parameter int LEN_W = 6,
  localparam int PTR_W = LEN_W + 1,
  localparam int BE_W  = DW_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        cmd_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [PTR_W-1:0]  wq_idx_o,
  input  logic [DW_W-1:0]   wq_lo_i,
  input  logic [DW_W-1:0]   wq_hi_i,
  input  logic [BE_W-1:0]   wq_be_lo_i,
  input  logic [BE_W-1:0]   wq_be_hi_i,
  output logic              frame_o,
  output logic              req64_o,
  output logic              irdy_o,
  input  logic              devsel_i,
  input  logic              trdy_i,
  input  logic              ack64_i,
  output logic [2*DW_W-1:0] ad_o,
  output logic [2*BE_W-1:0] cbe_o,
  input  logic [2*DW_W-1:0] ad_i,
  input  logic              par64_i,
  output logic              rd_valid_o,
  output logic              rd_wide_o,
  output logic [2*DW_W-1:0] rd_data_o,
  output logic              perr_o
);

  // Internal events, named for the checker.
  logic             xfer_w, wide_now_w, hi_on_w, seen_w, wide_dec_w, is_wr_w;
  logic [LEN_W-1:0] len_w;
  cmd_e             cmd_w;

  pci64_phase_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cmd_i     (cmd_e'(cmd_i)),
    .len_i     (len_i),
    .devsel_i  (devsel_i),
    .trdy_i    (trdy_i),
    .ack64_i   (ack64_i),
    .frame_o   (frame_o),
    .irdy_o    (irdy_o),
    .req64_o   (req64_o),
    .ptr_o     (wq_idx_o),
    .len_o     (len_w),
    .cmd_o     (cmd_w),
    .is_wr_o   (is_wr_w),
    .hi_on_o   (hi_on_w),
    .xfer_o    (xfer_w),
    .wide_now_o(wide_now_w),
    .seen_o    (seen_w),
    .wide_dec_o(wide_dec_w)
  );

  pci64_lane_steer #(.DW_W(DW_W), .LEN_W(LEN_W)) u_steer (
    .active_i  (irdy_o),
    .is_wr_i   (is_wr_w),
    .hi_on_i   (hi_on_w),
    .ptr_i     (wq_idx_o),
    .len_i     (len_w),
    .wq_lo_i   (wq_lo_i),
    .wq_hi_i   (wq_hi_i),
    .wq_be_lo_i(wq_be_lo_i),
    .wq_be_hi_i(wq_be_hi_i),
    .ad_o      (ad_o),
    .cbe_o     (cbe_o)
  );

  pci64_rd_capture #(.DW_W(DW_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_i    (xfer_w),
    .is_rd_i   (!is_wr_w),
    .wide_i    (wide_now_w),
    .ad_i      (ad_i),
    .par64_i   (par64_i),
    .cbe_hi_i  (cbe_o[2*BE_W-1:BE_W]),
    .rd_valid_o(rd_valid_o),
    .rd_wide_o (rd_wide_o),
    .rd_data_o (rd_data_o),
    .perr_o    (perr_o)
  );

endmodule

// File: rtl/pci64_steer_sva.sv
module pci64_steer_sva #(
  parameter int BE_W  = 4,
  parameter int PTR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame,
  input logic              req64,
  input logic              irdy,
  input logic [2*BE_W-1:0] cbe,
  input logic [PTR_W-1:0]  idx,
  input logic              xfer,
  input logic              wide_now,
  input logic              hi_on,
  input logic              seen,
  input logic              wide_dec,
  input logic              is_wr,
  input logic [1:0]        cmd,
  input logic              rd_valid,
  input logic              perr
);

  a_r2_req64_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    req64 |-> frame);

  a_r2_no_req64_narrow_cmds: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && cmd[1]) |-> !req64);

  a_r3_decision_held: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(seen)) |-> $stable(wide_dec));

  a_r3_wide_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && wide_now) |=> (idx == $past(idx) + PTR_W'(2)));

  a_r4_narrow_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wide_now) |=> (idx == $past(idx) + PTR_W'(1)));

  a_r7_hold_without_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy && !xfer) |=> $stable(idx));

  a_r6_read_be_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy && hi_on && !is_wr) |-> (cbe == '0));

  a_r11_narrow_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy && seen && !wide_dec) |-> (cbe[2*BE_W-1:BE_W] == '1));

  a_r8_rdvalid_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(xfer && !is_wr));

  a_r9_perr_after_wide: assert property (@(posedge clk) disable iff (!rst_n)
    perr |-> $past(xfer && wide_now && !is_wr));

endmodule

bind pci64_init_steer pci64_steer_sva #(.BE_W(BE_W), .PTR_W(PTR_W)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .frame   (frame_o),
  .req64   (req64_o),
  .irdy    (irdy_o),
  .cbe     (cbe_o),
  .idx     (wq_idx_o),
  .xfer    (xfer_w),
  .wide_now(wide_now_w),
  .hi_on   (hi_on_w),
  .seen    (seen_w),
  .wide_dec(wide_dec_w),
  .is_wr   (is_wr_w),
  .cmd     (cmd_w),
  .rd_valid(rd_valid_o),
  .perr    (perr_o)
);

// File: tb/sim_pci64_init_steer.sv
module sim_pci64_init_steer;
  localparam int DW_W = 32, LEN_W = 6, PTR_W = LEN_W + 1, BE_W = DW_W / 8;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [1:0] cmd_i = 2'd0;
  logic [LEN_W-1:0] len_i = 1;
  logic [PTR_W-1:0] wq_idx_o;
  logic [DW_W-1:0] wq_lo_i, wq_hi_i;
  logic [BE_W-1:0] wq_be_lo_i, wq_be_hi_i;
  logic frame_o, req64_o, irdy_o;
  logic devsel_i = 1'b0, trdy_i = 1'b0, ack64_i = 1'b0, par64_i = 1'b0;
  logic [2*DW_W-1:0] ad_o, rd_data_o;
  logic [2*DW_W-1:0] ad_i = '0;
  logic [2*BE_W-1:0] cbe_o;
  logic rd_valid_o, rd_wide_o, perr_o;

  logic [DW_W-1:0] wmem [0:71];
  logic [BE_W-1:0] wbe  [0:71];

  assign wq_lo_i    = wmem[wq_idx_o];
  assign wq_hi_i    = wmem[wq_idx_o + 1];
  assign wq_be_lo_i = wbe[wq_idx_o];
  assign wq_be_hi_i = wbe[wq_idx_o + 1];

  pci64_init_steer u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Target model settings
  int t_dly = 0, t_cnt = 0, t_devcnt = 0;
  bit t_ack = 0, t_bad = 0, t_fast = 1;
  logic [15:0] lfsr = 16'hACE1;

  // Reference model state
  int m_st = 0, m_ptr = 0, m_len = 0, m_cmd = 0;
  bit m_seen = 0, m_wide = 0, m_req64 = 0, m_rv = 0, m_rwide = 0, m_perr = 0;
  logic [63:0] m_rdata = '0;

  always @(posedge clk) begin : model
    bit x, wn;
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_len = 0; m_cmd = 0; m_seen = 0; m_wide = 0;
      m_req64 = 0; m_rv = 0; m_perr = 0;
    end else begin
      x  = (m_st == 2) && devsel_i && trdy_i;
      wn = m_seen ? m_wide : (m_req64 && ack64_i);
      m_rv = x && (m_cmd != 0);
      m_perr = 0;
      if (m_rv) begin
        m_rwide = wn;
        m_rdata = wn ? ad_i : {32'h0, ad_i[31:0]};
        m_perr  = wn && (^{ad_i[63:32], 4'b0000, par64_i});
      end
      case (m_st)
        0: if (start_i) begin
             m_st = 1; m_cmd = int'(cmd_i); m_len = int'(len_i); m_ptr = 0;
             m_seen = 0; m_wide = 0; m_req64 = (cmd_i < 2);
           end
        1: m_st = 2;
        default: begin
          if (devsel_i && !m_seen) begin m_seen = 1; m_wide = m_req64 && ack64_i; end
          if (x) begin
            m_ptr += wn ? 2 : 1;
            if (m_ptr >= m_len) m_st = 0;
          end
        end
      endcase
    end
  end

  // Compare on every clock away from the active edge, then drive the target.
  always @(negedge clk) begin : cmp
    logic [63:0] e_ad;
    logic [7:0]  e_cbe;
    bit hi;
    string tag;
    cyc++;
    if (rst_n && !finished) begin
      hi = (m_st == 2) && m_req64 && (!m_seen || m_wide);
      e_ad = '0; e_cbe = 8'hFF;
      if (m_st == 2) begin
        if (m_cmd == 0) begin
          e_ad[31:0] = wmem[m_ptr]; e_cbe[3:0] = wbe[m_ptr];
          if (hi) begin
            e_ad[63:32] = wmem[m_ptr + 1];
            e_cbe[7:4]  = (m_ptr + 1 < m_len) ? wbe[m_ptr + 1] : 4'hF;
          end
        end else begin
          e_cbe = hi ? 8'h00 : 8'hF0;
        end
      end
      if (m_cmd != 0) tag = "R6";
      else if (m_seen && !m_wide) tag = "R4";
      else if (hi && (m_ptr + 1 >= m_len)) tag = "R5";
      else tag = "R3";
      chk(frame_o == (m_st != 0), "R11", "frame", 64'(frame_o), 64'(m_st != 0));
      chk(irdy_o == (m_st == 2), "R11", "irdy", 64'(irdy_o), 64'(m_st == 2));
      chk(req64_o == ((m_st != 0) && m_req64), "R2", "req64", 64'(req64_o),
          64'((m_st != 0) && m_req64));
      chk(int'(wq_idx_o) == m_ptr, "R7", "index", 64'(wq_idx_o), 64'(m_ptr));
      chk(ad_o == e_ad, tag, "ad", ad_o, e_ad);
      chk(cbe_o == e_cbe, tag, "cbe", 64'(cbe_o), 64'(e_cbe));
      chk(rd_valid_o == m_rv, "R8", "rd_valid", 64'(rd_valid_o), 64'(m_rv));
      if (m_rv) begin
        chk(rd_wide_o == m_rwide, "R8", "rd_wide", 64'(rd_wide_o), 64'(m_rwide));
        chk(rd_data_o == m_rdata, "R8", "rd_data", rd_data_o, m_rdata);
      end
      chk(perr_o == m_perr, "R9", "perr", 64'(perr_o), 64'(m_perr));
    end
    // target behaviour
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (irdy_o) begin
      devsel_i = (t_cnt >= t_dly);
      t_cnt++;
      if (devsel_i) begin
        ack64_i = (t_devcnt == 0) ? t_ack : lfsr[3];
        t_devcnt++;
      end else ack64_i = 1'b0;
      trdy_i  = devsel_i && (t_fast || lfsr[0]);
      ad_i    = {lfsr, ~lfsr, lfsr ^ 16'h5A5A, lfsr + 16'd7};
      par64_i = (^ad_i[63:32]) ^ (t_bad && lfsr[5]);
    end else begin
      devsel_i = 0; trdy_i = 0; ack64_i = 0; t_cnt = 0; t_devcnt = 0;
    end
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL R7 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic load_mem(input int seed);
    for (int i = 0; i < 72; i++) begin
      wmem[i] = 32'h1000_0000 + (i * 32'h0101_0103) + (seed * 32'h0011_0000);
      wbe[i]  = 4'((i + seed) * 5);
    end
  endtask

  task automatic run_txn(input int cmd, input int len, input int dly, input bit ack,
                         input bit bad, input bit fast, input bit busy_start);
    load_mem(len + cmd * 7);
    t_dly = dly; t_ack = ack; t_bad = bad; t_fast = fast;
    @(negedge clk);
    start_i = 1; cmd_i = 2'(cmd); len_i = LEN_W'(len);
    @(negedge clk);
    start_i = 0;
    if (busy_start) begin
      repeat (2) @(negedge clk);
      start_i = 1; cmd_i = 2'd3; len_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    while (frame_o) @(negedge clk);
    @(negedge clk);
    if (busy_start)
      chk(!frame_o, "R10", "no restart after busy start", 64'(frame_o), 64'd0);
  endtask

  initial begin
    load_mem(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!frame_o && !req64_o && !irdy_o, "R1", "control", 64'({frame_o, req64_o, irdy_o}), 64'd0);
    chk(ad_o == '0 && cbe_o == 8'hFF, "R1", "lanes", {ad_o[31:0], 24'd0, cbe_o}, {32'd0, 24'd0, 8'hFF});
    chk(!rd_valid_o && !perr_o && wq_idx_o == '0, "R1", "return", 64'({rd_valid_o, perr_o, wq_idx_o}), 64'd0);
    rst_n = 1;
    run_txn(0, 8, 0, 1, 0, 1, 0);   // R3 wide write
    run_txn(0, 7, 2, 1, 0, 0, 0);   // R5 odd final DWORD, R7 waits
    run_txn(0, 5, 1, 0, 0, 0, 0);   // R4 narrow fallback
    run_txn(1, 6, 0, 1, 1, 0, 0);   // R6 R8 R9 wide read, bad parity
    run_txn(1, 5, 3, 0, 0, 1, 0);   // R6 narrow read
    run_txn(2, 4, 0, 1, 0, 1, 0);   // R2 no wide request despite ack
    run_txn(3, 1, 1, 1, 0, 1, 0);   // R2 I/O or config
    run_txn(0, 1, 0, 1, 0, 1, 0);   // R5 single DWORD
    run_txn(0, 9, 2, 1, 0, 0, 1);   // R10 start while busy
    run_txn(0, 2, 3, 0, 0, 1, 0);   // R4 short narrow
    for (int k = 0; k < 24; k++)
      run_txn(int'($urandom % 4), 1 + int'($urandom % 20), int'($urandom % 4),
              1'($urandom), 1'($urandom), 1'($urandom), 0);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule